// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block slices every bit on a CAN bus into time quanta and tells the surrounding controller when to launch a new transmit value and when the received line holds a valid bit. A programmable divider turns the system clock into quantum ticks. Each bit is laid out as one synchronization quantum, a first timing segment built from a propagation part and a first phase part, and a second timing segment built from a second phase part. The sample strobe fires at the end of the first segment. The transmit strobe fires when a new bit begins.

Falling (recessive-to-dominant) transitions of the received line resynchronize the bit clock. A late transition stretches the first segment, and an early one trims the second, in both cases by no more than the configured jump width. An optional mode takes three samples one quantum apart and reports their majority. Segment and jump-width settings are checked against the standard compliance window. A setting outside that window raises an error flag and keeps the generator idle.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted, `tx_strobe`, `sample_strobe` and `cfg_err` are 0 and `rx_bit` is 1 (recessive).
- R2: With no line transitions, one bit lasts 1 + T1 + T2 quanta, where T1 = `prop_seg` + `phase1_seg` + 2 and T2 = `phase2_seg` + 1. `tx_strobe` pulses once at the start of each bit, and the first pulse comes on the first quantum tick after reset.
- R3: `sample_strobe` pulses T1 + 1 quanta after `tx_strobe`, that is, at the end of the first segment.
- R4: One quantum lasts `tq_div` + 1 clock cycles.
- R5: The setting is legal only when all of the following hold: T2 is between 2 and 8; T1 is between 5 and 10 when T2 = 2, and between T2 + 1 and T2 + 8 otherwise; the jump width J = `jump_sel` + 1 is at most min(T2, 4). On an illegal setting, `cfg_err` is 1 and neither strobe pulses.
- R6: With `triple_en` = 0, `rx_bit` takes the value of `rx_in` in the sample quantum. `rx_bit` changes only in the cycle in which `sample_strobe` is 1.
- R7: With `triple_en` = 1, `rx_bit` is the majority of `rx_in` in the sample quantum and in the two quanta before it.
- R8: A falling edge seen in the first segment at quantum position p (counted from 1) lengthens that segment by min(p, J) quanta.
- R9: A falling edge seen in the second segment shortens it by J quanta when more than J quanta of the segment remain, counting the quantum that holds the edge.
- R10: A falling edge in the second segment with at most J quanta remaining ends the bit at once. The quantum that holds the edge becomes the next bit's synchronization quantum, and `tx_strobe` pulses at its end.
- R11: A falling edge in the synchronization quantum causes no adjustment, and at most one edge per bit is used for resynchronization.
- R12: Each strobe is high for exactly one clock cycle, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_div | input | DIV_W | Clock cycles per quantum, minus one |
| prop_seg | input | PROP_W | Propagation part of the first segment |
| phase1_seg | input | PH1_W | First phase part of the first segment |
| phase2_seg | input | PH2_W | Second segment length minus one |
| jump_sel | input | SJW_W | Resynchronization jump width minus one |
| triple_en | input | 1 | 1 selects the majority of three samples |
| rx_in | input | 1 | Received bus level, already synchronized (1 = recessive) |
| tx_strobe | output | 1 | One-cycle pulse at the start of a bit |
| sample_strobe | output | 1 | One-cycle pulse when `rx_bit` is updated |
| rx_bit | output | 1 | Most recently sampled bit value |
| cfg_err | output | 1 | The setting is outside the compliance window |

## Verification
A corrupted segment counter or length register shows up at once as a shifted `sample_strobe` or a changed spacing between `tx_strobe` pulses within the same bit. The bench therefore measures both distances in quanta for every legal setting. A wrong edge-handling decision changes only the bit in which the edge falls, so each resynchronization case places one falling edge in a chosen quantum and measures that bit alone. Sampling errors appear at the first `sample_strobe` through `rx_bit`, and line patterns are chosen so that single and majority sampling give different answers.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    BT_IDLE = 2'd0,
    BT_SYNC = 2'd1,
    BT_SEG1 = 2'd2,
    BT_SEG2 = 2'd3
  } bt_phase_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;

  assign tick = run && (pcnt_q == div);

  always_comb begin
    if (!run || tick) pcnt_d = '0;
    else              pcnt_d = pcnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/can_bt_cfg_check.sv
module can_bt_cfg_check #(
  parameter int PROP_W = 3,
  parameter int PH1_W  = 3,
  parameter int PH2_W  = 3,
  parameter int SJW_W  = 2,
  parameter int SEG_W  = 6
) (
  input  logic [PROP_W-1:0] prop,
  input  logic [PH1_W-1:0]  ph1,
  input  logic [PH2_W-1:0]  ph2,
  input  logic [SJW_W-1:0]  sjw,
  output logic [SEG_W-1:0]  tseg1,
  output logic [SEG_W-1:0]  tseg2,
  output logic [SEG_W-1:0]  jump,
  output logic              cfg_ok
);
  localparam logic [SEG_W-1:0] T2_LO   = SEG_W'(2);
  localparam logic [SEG_W-1:0] T2_HI   = SEG_W'(8);
  localparam logic [SEG_W-1:0] J_CAP   = SEG_W'(4);
  localparam logic [SEG_W-1:0] T1_SPAN = SEG_W'(8);
  localparam logic [SEG_W-1:0] T1_MIN2 = SEG_W'(5);

  logic [SEG_W-1:0] t1_lo, t1_hi, j_hi;

  always_comb begin
    tseg1  = SEG_W'(prop) + SEG_W'(ph1) + SEG_W'(2);
    tseg2  = SEG_W'(ph2) + SEG_W'(1);
    jump   = SEG_W'(sjw) + SEG_W'(1);
    t1_lo  = (tseg2 == T2_LO) ? T1_MIN2 : tseg2 + SEG_W'(1);
    t1_hi  = tseg2 + T1_SPAN;
    j_hi   = (tseg2 < J_CAP) ? tseg2 : J_CAP;
    cfg_ok = (tseg2 >= T2_LO) && (tseg2 <= T2_HI) &&
             (tseg1 >= t1_lo) && (tseg1 <= t1_hi) && (jump <= j_hi);
  end
endmodule

// File: rtl/can_bt_line_mon.sv
module can_bt_line_mon (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  output logic       fall_edge,
  output logic [1:0] hist
);
  logic last_q, older_q;

  assign fall_edge = tick && last_q && !rx_in;
  assign hist      = {older_q, last_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 1'b1;
      older_q <= 1'b1;
    end else if (tick) begin
      last_q  <= rx_in;
      older_q <= last_q;
    end
  end
endmodule

// File: rtl/can_bt_seg_fsm.sv
module can_bt_seg_fsm
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ok,
  input  logic             tick,
  input  logic [SEG_W-1:0] tseg1,
  input  logic [SEG_W-1:0] tseg2,
  input  logic [SEG_W-1:0] jump,
  input  logic             triple,
  input  logic             rx_in,
  input  logic [1:0]       hist,
  input  logic             fall_edge,
  output logic             tx_strobe,
  output logic             sample_strobe,
  output logic             rx_bit
);
  bt_phase_e        phase_q, phase_d;
  logic [SEG_W-1:0] cnt_q, cnt_d, len1_q, len1_d, len2_q, len2_d;
  logic             used_q, used_d, tx_q, tx_d, smp_q, smp_d, bit_q, bit_d;
  logic             edge_ok;
  logic [SEG_W-1:0] len1_eff, len2_eff, remain, early;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    len1_d   = len1_q;
    len2_d   = len2_q;
    used_d   = used_q;
    bit_d    = bit_q;
    tx_d     = 1'b0;
    smp_d    = 1'b0;
    edge_ok  = fall_edge && !used_q;
    early    = (cnt_q < jump) ? cnt_q : jump;
    len1_eff = edge_ok ? tseg1 + early : len1_q;
    remain   = len2_q - cnt_q + SEG_W'(1);
    len2_eff = edge_ok ? len2_q - jump : len2_q;
    if (!cfg_ok) begin
      phase_d = BT_IDLE;
      cnt_d   = '0;
      used_d  = 1'b0;
    end else if (tick) begin
      unique case (phase_q)
        BT_IDLE: begin
          phase_d = BT_SYNC;
          tx_d    = 1'b1;
          used_d  = 1'b0;
        end
        BT_SYNC: begin
          phase_d = BT_SEG1;
          cnt_d   = SEG_W'(1);
          len1_d  = tseg1;
          if (fall_edge) used_d = 1'b1;
        end
        BT_SEG1: begin
          len1_d = len1_eff;
          if (edge_ok) used_d = 1'b1;
          if (cnt_q >= len1_eff) begin
            smp_d   = 1'b1;
            bit_d   = triple ? vote3(rx_in, hist[0], hist[1]) : rx_in;
            phase_d = BT_SEG2;
            cnt_d   = SEG_W'(1);
            len2_d  = tseg2;
          end else begin
            cnt_d = cnt_q + SEG_W'(1);
          end
        end
        BT_SEG2: begin
          if (edge_ok && (remain <= jump)) begin
            phase_d = BT_SEG1;
            cnt_d   = SEG_W'(1);
            len1_d  = tseg1;
            tx_d    = 1'b1;
            used_d  = 1'b1;
          end else if (cnt_q >= len2_eff) begin
            phase_d = BT_SYNC;
            tx_d    = 1'b1;
            used_d  = 1'b0;
          end else begin
            cnt_d  = cnt_q + SEG_W'(1);
            len2_d = len2_eff;
            if (edge_ok) used_d = 1'b1;
          end
        end
        default: phase_d = BT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= BT_IDLE;
      cnt_q   <= '0;
      len1_q  <= '0;
      len2_q  <= '0;
      used_q  <= 1'b0;
      tx_q    <= 1'b0;
      smp_q   <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      len1_q  <= len1_d;
      len2_q  <= len2_d;
      used_q  <= used_d;
      tx_q    <= tx_d;
      smp_q   <= smp_d;
      bit_q   <= bit_d;
    end
  end

  assign tx_strobe     = tx_q;
  assign sample_strobe = smp_q;
  assign rx_bit        = bit_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int DIV_W  = 6,
  parameter int PROP_W = 3,
  parameter int PH1_W  = 3,
  parameter int PH2_W  = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  tq_div,
  input  logic [PROP_W-1:0] prop_seg,
  input  logic [PH1_W-1:0]  phase1_seg,
  input  logic [PH2_W-1:0]  phase2_seg,
  input  logic [SJW_W-1:0]  jump_sel,
  input  logic              triple_en,
  input  logic              rx_in,
  output logic              tx_strobe,
  output logic              sample_strobe,
  output logic              rx_bit,
  output logic              cfg_err
);
  localparam int SEG_W = $clog2((1 << PROP_W) + (1 << PH1_W) + (1 << SJW_W) + 2) + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             cfg_ok, tick, fall_edge, err_q;
  logic [1:0]       hist;
  logic [SEG_W-1:0] tseg1, tseg2, jump;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  can_bt_cfg_check #(
    .PROP_W(PROP_W), .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W), .SEG_W(SEG_W)
  ) u_cfg (
    .prop(prop_seg), .ph1(phase1_seg), .ph2(phase2_seg), .sjw(jump_sel),
    .tseg1(tseg1), .tseg2(tseg2), .jump(jump), .cfg_ok(cfg_ok)
  );

  can_bt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_s_n), .run(cfg_ok), .div(tq_div), .tick(tick)
  );

  can_bt_line_mon u_line (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .rx_in(rx_in),
    .fall_edge(fall_edge), .hist(hist)
  );

  can_bt_seg_fsm #(.SEG_W(SEG_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .cfg_ok(cfg_ok), .tick(tick),
    .tseg1(tseg1), .tseg2(tseg2), .jump(jump), .triple(triple_en),
    .rx_in(rx_in), .hist(hist), .fall_edge(fall_edge),
    .tx_strobe(tx_strobe), .sample_strobe(sample_strobe), .rx_bit(rx_bit)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= !cfg_ok;
  end
  assign cfg_err = err_q;
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_strobe,
  input logic sample_strobe,
  input logic rx_bit,
  input logic cfg_err
);
  // R12
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);

  // R12
  smp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_strobe && sample_strobe));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!tx_strobe && !sample_strobe));

  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |-> $stable(rx_bit));
endmodule

bind can_bit_timer can_bt_checker u_bt_chk (
  .clk(clk), .rst_n(rst_n), .tx_strobe(tx_strobe),
  .sample_strobe(sample_strobe), .rx_bit(rx_bit), .cfg_err(cfg_err)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  localparam int DIV_W = 6, PROP_W = 3, PH1_W = 3, PH2_W = 3, SJW_W = 2;
  localparam int NV = 11;
  // prop, ph1, ph2, jump_sel, exp_err, exp_sample_offset, exp_bit_length
  localparam int VEC [NV][7] = '{
    '{1, 2, 2, 0, 0,  6,  9},
    '{0, 1, 1, 0, 1,  0,  0},
    '{7, 7, 7, 3, 0, 17, 25},
    '{2, 1, 1, 1, 0,  6,  8},
    '{2, 1, 1, 2, 1,  0,  0},
    '{7, 4, 3, 0, 1,  0,  0},
    '{6, 4, 3, 3, 0, 13, 17},
    '{1, 2, 2, 3, 1,  0,  0},
    '{3, 3, 0, 0, 1,  0,  0},
    '{1, 1, 1, 0, 1,  0,  0},
    '{1, 1, 2, 0, 0,  5,  8}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [DIV_W-1:0]  tq_div;
  logic [PROP_W-1:0] prop_seg;
  logic [PH1_W-1:0]  phase1_seg;
  logic [PH2_W-1:0]  phase2_seg;
  logic [SJW_W-1:0]  jump_sel;
  logic triple_en, rx_in;
  logic tx_strobe, sample_strobe, rx_bit, cfg_err;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  can_bit_timer #(.DIV_W(DIV_W), .PROP_W(PROP_W), .PH1_W(PH1_W), .PH2_W(PH2_W), .SJW_W(SJW_W))
  u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .tq_div(tq_div), .prop_seg(prop_seg),
    .phase1_seg(phase1_seg), .phase2_seg(phase2_seg), .jump_sel(jump_sel),
    .triple_en(triple_en), .rx_in(rx_in), .tx_strobe(tx_strobe),
    .sample_strobe(sample_strobe), .rx_bit(rx_bit), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int p, input int a, input int b, input int j,
                       input int d, input bit t);
    @(negedge clk);
    rst_n      = 1'b0;
    rx_in      = 1'b1;
    prop_seg   = PROP_W'(p);
    phase1_seg = PH1_W'(a);
    phase2_seg = PH2_W'(b);
    jump_sel   = SJW_W'(j);
    tq_div     = DIV_W'(d);
    triple_en  = t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Waits for a bit start, then drives pat[k] during clock k after it.
  task automatic run_bit(input logic [31:0] pat, output int s_off,
                         output int p_len, output logic sbit);
    s_off = -1;
    p_len = -1;
    sbit  = 1'b1;
    do @(negedge clk); while (!tx_strobe);
    for (int k = 0; k < 64; k++) begin
      rx_in = (k < 32) ? pat[k] : pat[31];
      @(negedge clk);
      if (sample_strobe && s_off < 0) begin
        s_off = k + 1;
        sbit  = rx_bit;
      end
      if (tx_strobe) begin
        p_len = k + 1;
        break;
      end
    end
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s, p, n;
    logic b;
    rst_n = 1'b0;
    rx_in = 1'b1;
    prop_seg = 3'd1; phase1_seg = 3'd2; phase2_seg = 3'd2; jump_sel = 2'd0;
    tq_div = '0; triple_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_strobe == 1'b0, "R1 tx_strobe", int'(tx_strobe), 0);
    check(sample_strobe == 1'b0, "R1 sample_strobe", int'(sample_strobe), 0);
    check(rx_bit == 1'b1, "R1 rx_bit", int'(rx_bit), 1);
    check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);

    // Table walk: R2, R3, R5
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0, 1'b0);
      if (VEC[i][4] != 0) begin
        repeat (5) @(negedge clk);
        check(cfg_err == 1'b1, "R5 cfg_err set", int'(cfg_err), 1);
        n = 0;
        for (int c = 0; c < 30; c++) begin
          @(negedge clk);
          if (tx_strobe || sample_strobe) n++;
        end
        check(n == 0, "R5 idle strobes", n, 0);
      end else begin
        run_bit(32'hFFFF_FFFF, s, p, b);
        check(cfg_err == 1'b0, "R5 cfg_err clear", int'(cfg_err), 0);
        check(s == VEC[i][5], "R3 sample offset", s, VEC[i][5]);
        check(p == VEC[i][6], "R2 bit length", p, VEC[i][6]);
      end
    end

    // R4 quantum of three clocks
    setup(1, 2, 2, 0, 2, 1'b0);
    run_bit(32'hFFFF_FFFF, s, p, b);
    check(s == 18, "R4 sample offset", s, 18);
    check(p == 27, "R4 bit length", p, 27);

    // R7 majority: samples 0,0,1
    setup(1, 2, 2, 1, 0, 1'b1);
    run_bit(32'hFFFF_FFE0, s, p, b);
    check(b == 1'b0, "R7 majority bit", int'(b), 0);
    check(p == 9, "R11 sync edge no adjust", p, 9);

    // R6 single sample of same pattern
    setup(1, 2, 2, 1, 0, 1'b0);
    run_bit(32'hFFFF_FFE0, s, p, b);
    check(b == 1'b1, "R6 single sample bit", int'(b), 1);
    check(s == 6, "R6 sample offset", s, 6);

    // R8 late edge at first-segment position 3, jump 2
    setup(1, 2, 2, 1, 0, 1'b0);
    run_bit(32'h0000_0007, s, p, b);
    check(s == 8, "R8 lengthened sample", s, 8);
    check(p == 11, "R8 lengthened bit", p, 11);
    check(b == 1'b0, "R6 sampled dominant", int'(b), 0);

    // R9 early edge, 3 quanta left, jump 1
    setup(1, 2, 2, 0, 0, 1'b0);
    run_bit(32'h0000_003F, s, p, b);
    check(s == 6, "R9 sample offset", s, 6);
    check(p == 8, "R9 shortened bit", p, 8);

    // R10 early edge, 3 quanta left, jump 3
    setup(1, 2, 2, 2, 0, 1'b0);
    run_bit(32'h0000_003F, s, p, b);
    check(p == 7, "R10 restarted bit", p, 7);

    // R11 second edge in same bit ignored
    setup(1, 2, 2, 1, 0, 1'b0);
    run_bit(32'h0000_0002, s, p, b);
    check(s == 6, "R11 sample offset", s, 6);
    check(p == 9, "R11 bit length", p, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule